// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix-Multiply Array

The block multiplies one tile, C = A × B. It uses a ROWS × COLS grid of processing elements (16 × 16 by default) and an inner dimension of KDIM (16 by default). Each processing element owns one element of C for the whole computation and keeps its partial sum locally. Operands of A come in along the left edge and move rightwards one element per cycle. Operands of B come in along the top edge and move downwards one element per cycle. An internal skew network delays row i of A by i cycles and column j of B by j cycles. Because of this, A[i][k] and B[k][j] arrive at element (i,j) in the same cycle.

Two numeric modes are available. In integer mode the low byte of each operand is a signed 8-bit value, and the products are summed exactly into a signed 32-bit accumulator. In bfloat16 mode each 16-bit operand is a raw bfloat16 pattern. It is widened to FP32 by appending sixteen zero bits, the exact product is formed, and that product is added into an FP32 accumulator with round-to-nearest-even.

A small controller sequences each run with the states IDLE, STREAM, DRAIN, READ and DONE.
- start moves IDLE or DONE to STREAM and latches the mode.
- STREAM lasts KDIM cycles, then the block moves to DRAIN.
- DRAIN lasts ROWS+COLS-2 cycles, then the block moves to READ.
- READ presents one result row per cycle for ROWS cycles, then the block moves to DONE.
- clear returns any state to IDLE.

Top module: `osmm_array`

## Requirements
- R1: When mode is 0, bits [7:0] of every operand are a signed int8 and bits [15:8] are ignored. Each result word is the exact two's-complement int32 sum over k of A[i][k]·B[k][j]. This includes -128 × -128 = 16384, with no saturation.
- R2: When mode is 1, every operand is a bfloat16 pattern (sign [15], exponent [14:7], fraction [6:0]) and is widened to FP32 as {op,16'h0000}. Each product is exact. Products are added into the FP32 accumulator in the order k = 0..KDIM-1, each addition rounded to nearest-even. An operand whose exponent field is 0 counts as a signed zero. A sum that cancels exactly gives +0. Results are FP32 bit patterns.
- R3: start is a single-cycle pulse in cycle S. The operands for index k are presented in cycle S+1+k, for k = 0..KDIM-1: a_in[i] = A[i][k] and b_in[j] = B[k][j].
- R4: res_valid rises in cycle S+KDIM+ROWS+COLS-1, which is S+47 by default. Rows are then delivered one per cycle in ascending order, with res_row = r and res_data[j] = C[r][j] (bits [32j+31:32j]).
- R5: done rises in the cycle after the last row. It stays high until the next start or clear.
- R6: A clear pulse, in any state, zeroes every accumulator and discards operands still travelling through the array. In the following cycle res_valid and done are 0.
- R7: A start with no clear in between adds the new products onto the sums already held.
- R8: A start pulse during STREAM, DRAIN or READ is ignored. Timing and results are unchanged.
- R9: The mode is sampled together with start. Changes to the mode input during a run have no effect.
- R10: After reset, res_valid and done are 0 and every accumulator is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Zero all accumulators and abort any run |
| start | input | 1 | Begin a run; ignored while busy |
| mode | input | 1 | 0 = int8/int32, 1 = bfloat16/FP32 |
| a_in | input | ROWS×16 | Column k of A, one operand per row |
| b_in | input | COLS×16 | Row k of B, one operand per column |
| res_valid | output | 1 | A result row is on res_data |
| res_row | output | clog2(ROWS) | Index of the row on res_data |
| res_data | output | COLS×32 | One row of C, 32 bits per element |
| done | output | 1 | Readout finished, results final |

## Verification
The hardest situation to reach from the ports is an FP32 addition whose rounding decision depends on the guard and sticky bits, or whose operands cancel exactly. Random operands seldom produce these cases by accident. The stimulus therefore includes a wide-exponent pattern that adds products of very different scale, and a paired-sign pattern whose products cancel to exactly zero at every element. Expected values come from a double-precision model, rounded back to FP32 after every step. A second hard case is a clear that arrives while operands are still inside the skew network. The bench aborts a run mid-stream and then runs a fresh product, which must show no leftover contribution.

// File: rtl/osmm_pkg.sv
package osmm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STREAM,
        ST_DRAIN,
        ST_READ,
        ST_DONE
    } osmm_state_t;

    localparam int OP_W  = 16;
    localparam int ACC_W = 32;

    // Exact product of two FP32 values whose low 16 fraction bits are zero.
    function automatic logic [31:0] fp32_mul_narrow(input logic [31:0] x, input logic [31:0] y);
        logic        s;
        logic [15:0] p;
        logic [22:0] f;
        int          e;
        s = x[31] ^ y[31];
        if (x[30:23] == 8'd0 || y[30:23] == 8'd0) return {s, 31'd0};
        p = {1'b1, x[22:16]} * {1'b1, y[22:16]};
        e = int'(x[30:23]) + int'(y[30:23]) - 127;
        if (p[15]) begin
            f = {p[14:0], 8'd0};
            e = e + 1;
        end else begin
            f = {p[13:0], 9'd0};
        end
        if (e >= 255) return {s, 8'hFF, 23'd0};
        if (e <= 0)   return {s, 31'd0};
        return {s, e[7:0], f};
    endfunction

    // FP32 addition, round to nearest even, results below normal range flush to zero.
    function automatic logic [31:0] fp32_add_rne(input logic [31:0] xi, input logic [31:0] yi);
        logic [31:0] x, y;
        logic [26:0] mx, my;
        logic [27:0] sum;
        logic [24:0] rnd;
        logic        stk, g, rs, up, found;
        int          sh, er, lz;
        if (xi[30:23] == 8'd0 && yi[30:23] == 8'd0) return {xi[31] & yi[31], 31'd0};
        if (yi[30:23] == 8'd0) return xi;
        if (xi[30:23] == 8'd0) return yi;
        if (xi[30:0] < yi[30:0]) begin
            x = yi;
            y = xi;
        end else begin
            x = xi;
            y = yi;
        end
        mx = {1'b1, x[22:0], 3'b000};
        my = {1'b1, y[22:0], 3'b000};
        sh = int'(x[30:23]) - int'(y[30:23]);
        if (sh > 26) begin
            stk = |my;
            my  = 27'd0;
        end else begin
            stk = |(my & ((27'd1 << sh) - 27'd1));
            my  = my >> sh;
        end
        my[0] = my[0] | stk;
        er = int'(x[30:23]);
        if (x[31] == y[31]) begin
            sum = {1'b0, mx} + {1'b0, my};
            if (sum[27]) begin
                sum = {1'b0, sum[27:2], sum[1] | sum[0]};
                er  = er + 1;
            end
        end else begin
            sum = {1'b0, mx} - {1'b0, my};
            if (sum == 28'd0) return 32'd0;
            lz    = 0;
            found = 1'b0;
            for (int b = 26; b >= 0; b--) begin
                if (!found) begin
                    if (sum[b]) found = 1'b1;
                    else        lz = lz + 1;
                end
            end
            sum = sum << lz;
            er  = er - lz;
        end
        g   = sum[2];
        rs  = sum[1] | sum[0];
        up  = g & (rs | sum[3]);
        rnd = {1'b0, sum[26:3]} + {24'd0, up};
        if (rnd[24]) begin
            rnd = rnd >> 1;
            er  = er + 1;
        end
        if (er >= 255) return {x[31], 8'hFF, 23'd0};
        if (er <= 0)   return {x[31], 31'd0};
        return {x[31], er[7:0], rnd[22:0]};
    endfunction

endpackage

// File: rtl/osmm_skew.sv
module osmm_skew #(
    parameter int LANES = 16,
    parameter int W     = 17
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      flush,
    input  logic [LANES-1:0][W-1:0]   din,
    output logic [LANES-1:0][W-1:0]   dout
);

    // Lane l is delayed by l cycles.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l == 0) begin : g_direct
            assign dout[l] = din[l];
        end else begin : g_delay
            logic [W-1:0] pipe [l];
            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    for (int s = 0; s < l; s++) pipe[s] <= '0;
                end else begin
                    pipe[0] <= din[l];
                    for (int s = 1; s < l; s++) pipe[s] <= pipe[s-1];
                end
            end
            assign dout[l] = pipe[l-1];
        end
    end

endmodule

// File: rtl/osmm_pe.sv
module osmm_pe
    import osmm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              mode_i,
    input  logic [OP_W-1:0]   a_i,
    input  logic              a_vld_i,
    input  logic [OP_W-1:0]   b_i,
    input  logic              b_vld_i,
    output logic [OP_W-1:0]   a_o,
    output logic              a_vld_o,
    output logic [OP_W-1:0]   b_o,
    output logic              b_vld_o,
    output logic [ACC_W-1:0]  acc_o
);

    logic               fire;
    logic signed [15:0] int_prod;
    logic [ACC_W-1:0]   fp_prod;
    logic [ACC_W-1:0]   acc_next;

    assign fire = a_vld_i & b_vld_i;

    always_comb begin
        int_prod = $signed(a_i[7:0]) * $signed(b_i[7:0]);
        fp_prod  = fp32_mul_narrow({a_i, 16'h0000}, {b_i, 16'h0000});
        if (mode_i) acc_next = fp32_add_rne(acc_o, fp_prod);
        else        acc_next = acc_o + {{16{int_prod[15]}}, int_prod};
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            a_o     <= '0;
            b_o     <= '0;
            a_vld_o <= 1'b0;
            b_vld_o <= 1'b0;
            acc_o   <= '0;
        end else begin
            a_o     <= a_i;
            b_o     <= b_i;
            a_vld_o <= a_vld_i;
            b_vld_o <= b_vld_i;
            if (fire) acc_o <= acc_next;
        end
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!fire && !clear_i) |=> $stable(acc_o)); // R7

    AST_INT_EXACT: assert property (@(posedge clk) disable iff (rst)
        (fire && !clear_i && !mode_i && a_i[7:0] == 8'h80 && b_i[7:0] == 8'h80)
        |=> acc_o == $past(acc_o) + 32'd16384); // R1

endmodule

// File: rtl/osmm_ctrl.sv
module osmm_ctrl
    import osmm_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    parameter int KDIM = 16,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(KDIM + ROWS + COLS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          start_i,
    input  logic          mode_i,
    output logic          feed_en_o,
    output logic          mode_o,
    output logic          res_valid_o,
    output logic [RW-1:0] res_row_o,
    output logic          done_o
);

    localparam int DRAIN_LEN = ROWS + COLS - 2;

    osmm_state_t state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          busy;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt + CW'(1);
        unique case (state)
            ST_IDLE, ST_DONE: begin
                cnt_nx = '0;
                if (start_i) state_nx = ST_STREAM;
            end
            ST_STREAM: begin
                if (cnt == CW'(KDIM - 1)) begin
                    state_nx = ST_DRAIN;
                    cnt_nx   = '0;
                end
            end
            ST_DRAIN: begin
                if (cnt == CW'(DRAIN_LEN - 1)) begin
                    state_nx = ST_READ;
                    cnt_nx   = '0;
                end
            end
            ST_READ: begin
                if (cnt == CW'(ROWS - 1)) begin
                    state_nx = ST_DONE;
                    cnt_nx   = '0;
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
        if (clear_i) begin
            state_nx = ST_IDLE;
            cnt_nx   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            mode_o <= 1'b0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            if ((state == ST_IDLE || state == ST_DONE) && start_i && !clear_i) mode_o <= mode_i;
        end
    end

    always_comb begin
        feed_en_o   = 1'b0;
        res_valid_o = 1'b0;
        done_o      = 1'b0;
        busy        = 1'b0;
        res_row_o   = cnt[RW-1:0];
        unique case (state)
            ST_IDLE:   ;
            ST_STREAM: begin feed_en_o = 1'b1; busy = 1'b1; end
            ST_DRAIN:  busy = 1'b1;
            ST_READ:   begin res_valid_o = 1'b1; busy = 1'b1; end
            ST_DONE:   done_o = 1'b1;
            default:   ;
        endcase
    end

    AST_STREAM_COUNT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STREAM && $past(state) == ST_STREAM) |-> cnt == $past(cnt) + CW'(1)); // R3

    AST_ROW_ORDER: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && $past(res_valid_o)) |-> res_row_o == $past(res_row_o) + RW'(1)); // R4

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done_o && !clear_i && !start_i) |=> done_o); // R5

    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (!res_valid_o && !done_o)); // R6

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && start_i && !clear_i) |=> state != ST_STREAM); // R8

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && !clear_i) |=> $stable(mode_o)); // R9

endmodule

// File: rtl/osmm_array.sv
module osmm_array
    import osmm_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    parameter int KDIM = 16,
    localparam int RW  = $clog2(ROWS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic                         start,
    input  logic                         mode,
    input  logic [ROWS-1:0][OP_W-1:0]    a_in,
    input  logic [COLS-1:0][OP_W-1:0]    b_in,
    output logic                         res_valid,
    output logic [RW-1:0]                res_row,
    output logic [COLS-1:0][ACC_W-1:0]   res_data,
    output logic                         done
);

    logic feed_en;
    logic mode_q;

    logic [ROWS-1:0][OP_W:0] a_skin, a_skout;
    logic [COLS-1:0][OP_W:0] b_skin, b_skout;

    logic [OP_W-1:0]  ah  [ROWS][COLS+1];
    logic             av  [ROWS][COLS+1];
    logic [OP_W-1:0]  bh  [ROWS+1][COLS];
    logic             bv  [ROWS+1][COLS];
    logic [ACC_W-1:0] acc [ROWS][COLS];

    osmm_ctrl #(.ROWS(ROWS), .COLS(COLS), .KDIM(KDIM)) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (clear),
        .start_i     (start),
        .mode_i      (mode),
        .feed_en_o   (feed_en),
        .mode_o      (mode_q),
        .res_valid_o (res_valid),
        .res_row_o   (res_row),
        .done_o      (done)
    );

    always_comb begin
        for (int i = 0; i < ROWS; i++) a_skin[i] = feed_en ? {1'b1, a_in[i]} : '0;
        for (int j = 0; j < COLS; j++) b_skin[j] = feed_en ? {1'b1, b_in[j]} : '0;
    end

    osmm_skew #(.LANES(ROWS), .W(OP_W + 1)) skew_a_i (
        .clk (clk), .rst (rst), .flush (clear), .din (a_skin), .dout (a_skout)
    );

    osmm_skew #(.LANES(COLS), .W(OP_W + 1)) skew_b_i (
        .clk (clk), .rst (rst), .flush (clear), .din (b_skin), .dout (b_skout)
    );

    for (genvar i = 0; i < ROWS; i++) begin : g_left
        assign ah[i][0] = a_skout[i][OP_W-1:0];
        assign av[i][0] = a_skout[i][OP_W];
    end

    for (genvar j = 0; j < COLS; j++) begin : g_top
        assign bh[0][j] = b_skout[j][OP_W-1:0];
        assign bv[0][j] = b_skout[j][OP_W];
    end

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        for (genvar j = 0; j < COLS; j++) begin : g_col
            osmm_pe pe_i (
                .clk     (clk),
                .rst     (rst),
                .clear_i (clear),
                .mode_i  (mode_q),
                .a_i     (ah[i][j]),
                .a_vld_i (av[i][j]),
                .b_i     (bh[i][j]),
                .b_vld_i (bv[i][j]),
                .a_o     (ah[i][j+1]),
                .a_vld_o (av[i][j+1]),
                .b_o     (bh[i+1][j]),
                .b_vld_o (bv[i+1][j]),
                .acc_o   (acc[i][j])
            );
        end
    end

    always_comb begin
        res_data = '0;
        if (res_valid) begin
            for (int j = 0; j < COLS; j++) res_data[j] = acc[res_row][j];
        end
    end

endmodule

// File: tb/osmm_array_tb.sv
module osmm_array_tb_top;

    localparam int N = 16;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                clear = 1'b0;
    logic                start = 1'b0;
    logic                mode = 1'b0;
    logic [N-1:0][15:0]  a_in = '0;
    logic [N-1:0][15:0]  b_in = '0;
    logic                res_valid;
    logic [3:0]          res_row;
    logic [N-1:0][31:0]  res_data;
    logic                done;

    always #2.5 clk = ~clk;

    osmm_array dut_i (
        .clk (clk), .rst (rst), .clear (clear), .start (start), .mode (mode),
        .a_in (a_in), .b_in (b_in), .res_valid (res_valid), .res_row (res_row),
        .res_data (res_data), .done (done)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [15:0] A [N][N];
    logic [15:0] B [N][N];
    logic [31:0] expv [N][N];

    // {mode, pattern[1:0], clear_first, seed[7:0]}
    localparam logic [11:0] VEC [9] = '{
        {1'b0, 2'd0, 1'b1, 8'd11},
        {1'b0, 2'd2, 1'b1, 8'd12},
        {1'b0, 2'd3, 1'b0, 8'd13},
        {1'b0, 2'd1, 1'b1, 8'd14},
        {1'b1, 2'd0, 1'b1, 8'd21},
        {1'b1, 2'd1, 1'b1, 8'd22},
        {1'b1, 2'd2, 1'b1, 8'd23},
        {1'b1, 2'd3, 1'b1, 8'd24},
        {1'b1, 2'd0, 1'b0, 8'd25}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mix(input int unsigned s, input int unsigned n);
        logic [31:0] h;
        h = (s * 32'h9E3779B1) ^ (n * 32'h85EBCA6B);
        h = h ^ (h >> 15);
        h = h * 32'hC2B2AE35;
        h = h ^ (h >> 13);
        return h;
    endfunction

    function automatic logic [15:0] gen(input bit md, input int pat, input int seed,
                                         input int side, input int r, input int c);
        logic [31:0] h;
        h = mix(seed, side * 1000 + r * 16 + c + 1);
        if (!md) begin
            case (pat)
                0: return h[15:0];
                1: return side == 0 ? {h[15:8], (r == c) ? 8'd1 : 8'd0} : h[15:0];
                2: return {h[15:8], 8'h80};
                default: return side == 0 ? {h[15:8], ((r + c) % 2 == 0) ? 8'h7F : 8'h80}
                                          : {h[15:8], ((r + c) % 3 == 0) ? 8'h80 : 8'h7F};
            endcase
        end else begin
            case (pat)
                0: return {h[15], 8'(120 + int'(h[10:7])), h[6:0]};
                1: return side == 0 ? ((r == c) ? 16'h3F80 : 16'h0000)
                                    : {h[15], 8'(120 + int'(h[10:7])), h[6:0]};
                2: return {h[15], 8'(100 + int'(h[12:8]) + int'(h[4:0])), h[6:0]};
                default: begin
                    if (side == 0) return 16'h3FC0;
                    h = mix(seed, 5000 + (r / 2) * 16 + c);
                    return {(r % 2 == 1), 8'(120 + int'(h[10:7])), h[6:0]};
                end
            endcase
        end
    endfunction

    function automatic real f2r(input logic [31:0] x);
        if (x[30:23] == 8'd0) return $bitstoreal({x[31], 63'd0});
        return $bitstoreal({x[31], 11'(int'(x[30:23]) - 127 + 1023), x[22:0], 29'd0});
    endfunction

    function automatic logic [31:0] r2f(input real v);
        logic [63:0] b;
        logic [23:0] m;
        logic [24:0] mr;
        logic        up;
        int          e;
        b = $realtobits(v);
        if (b[62:0] == 63'd0) return {b[63], 31'd0};
        e  = int'(b[62:52]) - 1023 + 127;
        m  = {1'b1, b[51:29]};
        up = b[28] & ((|b[27:0]) | m[0]);
        mr = {1'b0, m} + {24'd0, up};
        if (mr[24]) begin
            mr = mr >> 1;
            e  = e + 1;
        end
        if (e >= 255) return {b[63], 8'hFF, 23'd0};
        if (e <= 0)   return {b[63], 31'd0};
        return {b[63], e[7:0], mr[22:0]};
    endfunction

    task automatic fill(input bit md, input int pat, input int seed);
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                A[i][k] = gen(md, pat, seed, 0, i, k);
                B[i][k] = gen(md, pat, seed, 1, i, k);
            end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) expv[i][j] = 32'd0;
    endtask

    task automatic model_run(input bit md);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                for (int k = 0; k < N; k++) begin
                    if (!md)
                        expv[i][j] = expv[i][j] + 32'(int'($signed(A[i][k][7:0])) * int'($signed(B[k][j][7:0])));
                    else
                        expv[i][j] = r2f(f2r(expv[i][j]) +
                                         f2r({A[i][k], 16'h0}) * f2r({B[k][j], 16'h0}));
                end
    endtask

    // Runs one product; returns after the row readout and the done check.
    task automatic run(input bit md, input bit do_clear, input bit flip_mode, input bit mid_start,
                       input string tag);
        int idx;
        if (do_clear) begin
            clear = 1'b1;
            @(negedge clk);
            clear = 1'b0;
            model_clear();
        end
        model_run(md);
        mode  = md;
        start = 1'b1;
        @(negedge clk);
        for (int k = 0; k < N; k++) begin
            start = mid_start && (k == 5);
            if (flip_mode && k == 3) mode = ~md;
            for (int i = 0; i < N; i++) a_in[i] = A[i][k];
            for (int j = 0; j < N; j++) b_in[j] = B[k][j];
            @(negedge clk);
        end
        start = 1'b0;
        a_in  = '0;
        b_in  = '0;
        idx   = 17;
        while (!res_valid && idx < 200) begin
            @(negedge clk);
            idx++;
        end
        chk(idx == 47, {tag, " R4 latency"}, 32'(idx), 32'd47);
        for (int r = 0; r < N; r++) begin
            chk(res_valid && res_row == 4'(r), {tag, " R4 row order"}, {27'd0, res_valid, res_row}, 32'(16 + r));
            for (int j = 0; j < N; j++)
                chk(res_data[j] == expv[r][j], $sformatf("%s R%0d C[%0d][%0d]", tag, md ? 2 : 1, r, j),
                    res_data[j], expv[r][j]);
            @(negedge clk);
        end
        chk(done && !res_valid, {tag, " R5 done raised"}, {30'd0, done, res_valid}, 32'd2);
        @(negedge clk);
        chk(done, {tag, " R5 done held"}, {31'd0, done}, 32'd1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!res_valid && !done, "R10 reset outputs", {30'd0, res_valid, done}, 32'd0);

        // R10: first run without clear relies on reset-zeroed accumulators.
        fill(1'b0, 0, 3);
        run(1'b0, 1'b0, 1'b0, 1'b0, "R10 fresh");

        // Table walk: R1, R2, R7 (entries without clear accumulate).
        for (int v = 0; v < 9; v++) begin
            fill(VEC[v][11], int'(VEC[v][10:9]), int'(VEC[v][7:0]));
            run(VEC[v][11], VEC[v][8], 1'b0, 1'b0, $sformatf("vec%0d", v));
        end

        // R9: mode flips mid-run are ignored.
        fill(1'b0, 0, 40);
        run(1'b0, 1'b1, 1'b1, 1'b0, "R9 int flip");
        fill(1'b1, 0, 41);
        run(1'b1, 1'b1, 1'b1, 1'b0, "R9 fp flip");

        // R8: start pulse during streaming is ignored.
        fill(1'b0, 3, 42);
        run(1'b0, 1'b1, 1'b0, 1'b1, "R8 busy start");

        // R6: clear mid-stream aborts and flushes operands in flight.
        fill(1'b0, 2, 43);
        mode  = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < N; i++) a_in[i] = A[i][k];
            for (int j = 0; j < N; j++) b_in[j] = B[k][j];
            @(negedge clk);
        end
        clear = 1'b1;
        a_in  = '0;
        b_in  = '0;
        @(negedge clk);
        clear = 1'b0;
        model_clear();
        chk(!res_valid && !done, "R6 quiet after clear", {30'd0, res_valid, done}, 32'd0);
        for (int t = 0; t < 60; t++) begin
            @(negedge clk);
            chk(!res_valid && !done, "R6 stays idle", {30'd0, res_valid, done}, 32'd0);
        end
        fill(1'b0, 0, 44);
        run(1'b0, 1'b0, 1'b0, 1'b0, "R6 after abort");

        // R1: extreme operands once more after a clear.
        fill(1'b0, 2, 45);
        run(1'b0, 1'b1, 1'b0, 1'b0, "R1 minus128");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule